// File: doc/BRIEF.md
# Bit-Flipping LDPC Decoder with Pinned Known Bits

This block corrects an 8-bit received word against a fixed rate-1/2 low-density parity-check code with four information bits and four parity bits. It uses hard decisions and a bit-flipping rule. Each clock cycle it computes the four parity checks. If any check fails, it finds the bits that sit in the most failing checks and inverts them.

A receiver often knows some codeword bits in advance, for example stuffing or repeated service data found by a higher protocol layer. The caller marks those bits in a mask and supplies their values. The decoder forces a marked bit to its supplied value at load time and again on every iteration, and never chooses it for inversion. Decoding then runs on the shorter code that is left. The mask and values are sampled live, so they may grow while a decode is running.

A decode starts with a one-cycle `start` pulse while the block is idle. It ends with a one-cycle `done` pulse together with the final codeword, a success flag and the number of flip iterations used.

Top module: `ldpc_bf_decoder`

## Requirements
- R1: After reset, `done` and `success` are 0, `codeword` is 0 and `iter_count` is 0.
- R2: A `start` pulse in idle loads `rx_bits` with every masked bit replaced by its `known_val` bit. A received error on a known bit is therefore removed before the first check: a word that is valid after substitution finishes with `iter_count` 0, and `done` rises two clock edges after the edge that samples `start`.
- R3: Bit 0 is v1 and bit 7 is v8. The four checks are v1^v2^v3^v4, v1^v4^v5^v8, v2^v5^v6^v7 and v2^v6^v7^v8, and a word is valid only when all four are 0.
- R4: When `done` is high, every codeword bit marked in `known_mask` equals its `known_val` bit.
- R5: When checks fail, each unknown bit is inverted if its count of failing checks equals the largest such count among the unknown bits and that count is nonzero. Each such step takes one clock and adds 1 to `iter_count`.
- R6: When all checks pass, `done` pulses for exactly one cycle with `success` 1. At that point `iter_count` holds the number of flip steps taken, and `done` arrives `iter_count`+2 edges after the start edge.
- R7: If the word is still invalid after MAX_ITER (default 16) flip steps, `done` pulses with `success` 0 and `iter_count` equal to MAX_ITER.
- R8: `known_mask` and `known_val` are sampled again in every iteration, so bits marked known after the start take effect from the next check onward.
- R9: A `start` pulse while a decode is running is ignored.
- R10: While idle and without `start`, `codeword`, `success` and `iter_count` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (idle only) |
| rx_bits | input | 8 | Hard-decision received word, bit 0 = v1 |
| known_mask | input | 8 | 1 marks a bit as known |
| known_val | input | 8 | Values of the known bits |
| codeword | output | 8 | Working word, and the result when `done` is high |
| done | output | 1 | One-cycle end-of-decode pulse |
| success | output | 1 | All checks passed at the end |
| iter_count | output | 5 | Number of flip steps taken |

## Verification
Inputs used:
- A clean codeword with no mask shows that a valid word finishes with no flips.
- The same word with one parity-side error shows that the single largest-count bit is flipped in one step.
- An error placed on a bit that is also marked known shows that substitution at load removes it.
- A mask that asserts a wrong value on a bit shows that a known bit is pinned and never flipped.
- A fully masked, inconsistent word can never become valid, so it reaches the iteration limit and reports failure; a second `start` is also issued during that run.
- Setting the mask only after the load shows that known bits are sampled on every iteration: the run ends with no flips instead of one.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;
  localparam int unsigned CODE_N = 8;
  localparam int unsigned CODE_M = 4;
  localparam int unsigned CNT_W  = $clog2(CODE_M + 1);

  // parity-check rows, bit i of a row is codeword bit i (bit 0 = v1)
  localparam logic [CODE_M-1:0][CODE_N-1:0] PCHK_ROWS = {
    8'b1110_0010,   // v2 v6 v7 v8
    8'b0111_0010,   // v2 v5 v6 v7
    8'b1001_1001,   // v1 v4 v5 v8
    8'b0000_1111    // v1 v2 v3 v4
  };

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dec_state_e;

  function automatic logic [CODE_N-1:0] pin_known(
    input logic [CODE_N-1:0] word,
    input logic [CODE_N-1:0] mask,
    input logic [CODE_N-1:0] vals
  );
    return (word & ~mask) | (vals & mask);
  endfunction
endpackage

// File: rtl/ldpc_bf_syndrome.sv
module ldpc_bf_syndrome
  import ldpc_bf_pkg::*;
(
  input  logic [CODE_N-1:0] word,
  output logic [CODE_M-1:0] syn,
  output logic              syn_zero
);
  for (genvar c = 0; c < CODE_M; c++) begin : g_chk
    assign syn[c] = ^(word & PCHK_ROWS[c]);
  end

  assign syn_zero = (syn == '0);
endmodule

// File: rtl/ldpc_bf_flip.sv
module ldpc_bf_flip
  import ldpc_bf_pkg::*;
(
  input  logic [CODE_N-1:0] word,
  input  logic [CODE_M-1:0] syn,
  input  logic [CODE_N-1:0] known_mask,
  output logic [CODE_N-1:0] next_word
);
  logic [CODE_N-1:0][CNT_W-1:0] bad_cnt;
  logic [CNT_W-1:0]             max_cnt;
  logic [CODE_N-1:0]            flip_sel;

  for (genvar b = 0; b < CODE_N; b++) begin : g_bit
    always_comb begin
      bad_cnt[b] = '0;
      for (int c = 0; c < CODE_M; c++) begin
        bad_cnt[b] = bad_cnt[b] + CNT_W'(syn[c] & PCHK_ROWS[c][b]);
      end
    end
  end

  always_comb begin
    max_cnt = '0;
    for (int b = 0; b < CODE_N; b++) begin
      if (!known_mask[b] && (bad_cnt[b] > max_cnt)) begin
        max_cnt = bad_cnt[b];
      end
    end
  end

  for (genvar b = 0; b < CODE_N; b++) begin : g_sel
    assign flip_sel[b] = !known_mask[b] && (max_cnt != '0) && (bad_cnt[b] == max_cnt);
  end

  assign next_word = word ^ flip_sel;
endmodule

// File: rtl/ldpc_bf_ctrl.sv
module ldpc_bf_ctrl
  import ldpc_bf_pkg::*;
#(
  parameter  int unsigned MAX_ITER = 16,
  localparam int unsigned ITER_W   = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              syn_zero,
  output logic              load,
  output logic              step,
  output logic              finish,
  output logic              busy,
  output logic              done,
  output logic              success,
  output logic [ITER_W-1:0] iter_count
);
  dec_state_e        state_q, state_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;
  logic              ok_en;

  always_comb begin
    state_d = state_q;
    iter_d  = iter_q;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    ok_en   = 1'b0;
    ok_d    = ok_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          iter_d  = '0;
          load    = 1'b1;
        end
      end
      ST_RUN: begin
        if (syn_zero) begin
          finish  = 1'b1;
          ok_en   = 1'b1;
          ok_d    = 1'b1;
          state_d = ST_IDLE;
        end else if (iter_q == ITER_W'(MAX_ITER)) begin
          finish  = 1'b1;
          ok_en   = 1'b1;
          ok_d    = 1'b0;
          state_d = ST_IDLE;
        end else begin
          step    = 1'b1;
          iter_d  = iter_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
      done_q  <= done_d;
      if (ok_en) begin
        ok_q <= ok_d;
      end
    end
  end

  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;
  assign success    = ok_q;
  assign iter_count = iter_q;
endmodule

// File: rtl/ldpc_bf_decoder.sv
module ldpc_bf_decoder
  import ldpc_bf_pkg::*;
#(
  parameter  int unsigned MAX_ITER = 16,
  localparam int unsigned ITER_W   = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        rx_bits,
  input  logic [7:0]        known_mask,
  input  logic [7:0]        known_val,
  output logic [7:0]        codeword,
  output logic              done,
  output logic              success,
  output logic [ITER_W-1:0] iter_count
);
  logic [CODE_N-1:0] word_q, word_d;
  logic [CODE_N-1:0] word_pinned, word_flipped;
  logic [CODE_M-1:0] syn;
  logic              syn_zero;
  logic              load, step, finish, busy;
  logic              word_en;

  assign word_pinned = pin_known(word_q, known_mask, known_val);

  ldpc_bf_syndrome u_syn (
    .word     (word_pinned),
    .syn      (syn),
    .syn_zero (syn_zero)
  );

  ldpc_bf_flip u_flip (
    .word       (word_pinned),
    .syn        (syn),
    .known_mask (known_mask),
    .next_word  (word_flipped)
  );

  ldpc_bf_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .syn_zero   (syn_zero),
    .load       (load),
    .step       (step),
    .finish     (finish),
    .busy       (busy),
    .done       (done),
    .success    (success),
    .iter_count (iter_count)
  );

  always_comb begin
    word_en = load | step | finish;
    if (load) begin
      word_d = pin_known(rx_bits, known_mask, known_val);
    end else if (step) begin
      word_d = word_flipped;
    end else begin
      word_d = word_pinned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign codeword = word_q;
endmodule

// File: rtl/ldpc_bf_decoder_chk.sv
module ldpc_bf_decoder_chk #(
  parameter  int unsigned MAX_ITER = 16,
  localparam int unsigned ITER_W   = $clog2(MAX_ITER + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        known_mask,
  input logic [7:0]        known_val,
  input logic [7:0]        codeword,
  input logic              done,
  input logic              success,
  input logic [ITER_W-1:0] iter_count,
  input logic              busy
);
  // R6: end pulse lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3, R6: success only with every parity check satisfied
  a_r3_success_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && success) |->
      (!(^(codeword & 8'h0F)) && !(^(codeword & 8'h99)) &&
       !(^(codeword & 8'h72)) && !(^(codeword & 8'hE2))));

  // R4: known bits match their supplied values at the end
  a_r4_known_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((($past(known_mask)) & (codeword ^ $past(known_val))) == 8'h00));

  // R7: the flip count never passes the limit
  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count <= ITER_W'(MAX_ITER));

  // R10: idle with no start keeps results
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(codeword) && $stable(iter_count) && $stable(success)));

  // R9: a start while running does not end or restart the run
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind ldpc_bf_decoder ldpc_bf_decoder_chk #(.MAX_ITER(MAX_ITER)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .known_mask (known_mask),
  .known_val  (known_val),
  .codeword   (codeword),
  .done       (done),
  .success    (success),
  .iter_count (iter_count),
  .busy       (busy)
);

// File: tb/ldpc_bf_decoder_bench.sv
module ldpc_bf_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXI       = 16;

  logic       clk, rst_n, start;
  logic [7:0] rx_bits, known_mask, known_val;
  logic [7:0] codeword;
  logic       done, success;
  logic [4:0] iter_count;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int t0      = 0;
  bit finished = 0;

  ldpc_bf_decoder #(.MAX_ITER(MAXI)) u_ldpc_bf_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_bits(rx_bits),
    .known_mask(known_mask), .known_val(known_val), .codeword(codeword),
    .done(done), .success(success), .iter_count(iter_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int chk_bits [4][4] = '{'{0,1,2,3}, '{0,3,4,7}, '{1,4,5,6}, '{1,5,6,7}};
  bit   m_busy, m_done, m_succ;
  int   m_iter;
  bit [7:0] m_word;

  function automatic bit [7:0] frc(bit [7:0] w, bit [7:0] m, bit [7:0] v);
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m[i] ? v[i] : w[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_succ = 0; m_iter = 0; m_word = 0;
    end else begin
      bit [7:0] eff;
      int fails [4];
      int cnt [8];
      int any, best;
      cyc++;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_word = frc(rx_bits, known_mask, known_val);
          m_iter = 0; m_busy = 1;
        end
      end else begin
        eff = frc(m_word, known_mask, known_val);
        any = 0;
        for (int c = 0; c < 4; c++) begin
          fails[c] = 0;
          for (int k = 0; k < 4; k++) fails[c] ^= eff[chk_bits[c][k]];
          any += fails[c];
        end
        if (any == 0) begin
          m_word = eff; m_done = 1; m_succ = 1; m_busy = 0;
        end else if (m_iter == MAXI) begin
          m_word = eff; m_done = 1; m_succ = 0; m_busy = 0;
        end else begin
          for (int i = 0; i < 8; i++) cnt[i] = 0;
          for (int c = 0; c < 4; c++)
            for (int k = 0; k < 4; k++) cnt[chk_bits[c][k]] += fails[c];
          best = 0;
          for (int i = 0; i < 8; i++) if (!known_mask[i] && cnt[i] > best) best = cnt[i];
          for (int i = 0; i < 8; i++)
            if (!known_mask[i] && best > 0 && cnt[i] == best) eff[i] = ~eff[i];
          m_word = eff; m_iter++;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R6, R10)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done == m_done, "R6 per-cycle done", done, m_done);
      check(codeword == m_word, "R10 per-cycle codeword", codeword, m_word);
      check(iter_count == m_iter, "R5 per-cycle iter_count", iter_count, m_iter);
      if (m_done) check(success == m_succ, "R6 per-cycle success", success, m_succ);
    end
  end

  task automatic pulse_start(bit [7:0] rx, bit [7:0] m, bit [7:0] v);
    @(negedge clk);
    rx_bits = rx; known_mask = m; known_val = v; start = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    int guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: done never arrived actual=0 expected=1");
    end
    lat = cyc - t0 + 1;
  endtask

  localparam bit [7:0] GOOD = 8'hB9;  // v1 v4 v5 v6 v8 set, valid word

  initial begin
    int lat;
    start = 0; rx_bits = 0; known_mask = 0; known_val = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0, "R1 done", done, 0);
    check(success == 0, "R1 success", success, 0);
    check(codeword == 0, "R1 codeword", codeword, 0);
    check(iter_count == 0, "R1 iter_count", iter_count, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3, R6: clean codeword decodes with no flips
    pulse_start(GOOD, 8'h00, 8'h00);
    wait_done(lat);
    check(codeword == GOOD, "R3 clean codeword", codeword, GOOD);
    check(success == 1, "R6 clean success", success, 1);
    check(iter_count == 0, "R6 clean iter", iter_count, 0);
    check(lat == 2, "R6 clean latency", lat, 2);

    // R5: single error on v5 fixed in one step
    pulse_start(GOOD ^ 8'h10, 8'h00, 8'h00);
    wait_done(lat);
    check(codeword == GOOD, "R5 v5 error corrected", codeword, GOOD);
    check(iter_count == 1, "R5 one flip", iter_count, 1);
    check(lat == 3, "R6 latency after one flip", lat, 3);

    // R10: results hold while idle
    rx_bits = 8'h55; known_mask = 8'hFF; known_val = 8'h33;
    repeat (4) @(negedge clk);
    check(codeword == GOOD, "R10 hold codeword", codeword, GOOD);
    check(iter_count == 1, "R10 hold iter", iter_count, 1);

    // R2: error on a known bit removed at load
    pulse_start(GOOD ^ 8'h02, 8'h02, 8'h00);
    wait_done(lat);
    check(codeword == GOOD, "R2 known error removed", codeword, GOOD);
    check(iter_count == 0, "R2 no flips", iter_count, 0);
    check(lat == 2, "R2 latency", lat, 2);

    // R4: a wrong known value is pinned, never flipped
    pulse_start(GOOD, 8'h10, 8'h00);
    wait_done(lat);
    check(codeword[4] == 1'b0, "R4 known bit pinned", codeword[4], 0);

    // R7, R9: fully known inconsistent word hits the limit; extra start ignored
    pulse_start(8'h00, 8'hFF, 8'h01);
    repeat (3) @(negedge clk);
    rx_bits = GOOD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check(success == 0, "R7 failure flag", success, 0);
    check(iter_count == 5'(MAXI), "R7 iter at limit", iter_count, MAXI);
    check(codeword == 8'h01, "R7 codeword pinned", codeword, 8'h01);
    check(lat == MAXI + 2, "R9 run not restarted", lat, MAXI + 2);

    // R8: mask set after load is used from the first check
    pulse_start(GOOD ^ 8'h10, 8'h00, 8'h00);
    known_mask = 8'h10; known_val = 8'h10;
    wait_done(lat);
    check(codeword == GOOD, "R8 late mask codeword", codeword, GOOD);
    check(iter_count == 0, "R8 late mask no flips", iter_count, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule